// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block keeps, for every CPU of an interrupt controller, the record of which interrupt that CPU is servicing and which interrupts it preempted to get there. A priority selector outside the block supplies the best pending ID for each CPU, together with the priority table and the per-source configuration: trigger kind, 1-of-N or N-to-N delivery, enable, input level and CPU targets. The block turns acknowledge and end-of-interrupt requests into updates of the running state. It also emits pulses that tell the pending store to clear or to set bits.

On an acknowledge, the block answers with the offered ID if that ID outranks the running one. It then links the new ID back to the interrupt it preempted and makes the new ID the running one. On an end-of-interrupt there are two cases. If the ID is the running one, the running ID falls back along its back-link. If the ID is an older, preempted entry, a walk of one step per clock finds that entry and splices it out of the chain. Level-triggered sources that are still asserted are pended again when they complete.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset, every CPU's running ID is 1023, its running priority is 0x100 (256), busy is low, and no response, clear or set pulse is raised.
- R2: An acknowledge (req_op=0) is answered one cycle later with rsp_vld and rsp_id=1023, and changes no state, in these cases:
  - the offered ID is 1023 or is not below NIRQ;
  - the offered ID's 8-bit priority is not strictly below the CPU's running priority.
- R3: A successful acknowledge answers with the offered ID one cycle later. From that same cycle, the ID is the CPU's running ID and the CPU's running priority equals that ID's priority, zero-extended to 9 bits.
- R4: A successful acknowledge raises clr_vld with clr_id equal to the ID. clr_mask bit c stands for CPU c. The mask is all ones if the ID's 1-of-N bit is 1, and only the acknowledging CPU's bit otherwise.
- R5: An end-of-interrupt (req_op=1) issued while the CPU's running ID is 1023 has no effect at all, including no set pulse.
- R6: Completing the running ID makes its back-link the running ID in the next cycle. The running priority becomes that ID's priority, or 256 if the back-link is 1023.
- R7: Completing an ID that is not running leaves the running ID unchanged. Busy stays high for k cycles, where k is the position of the ID in the chain (the running ID is position 0). The ID is removed so that its predecessor links to its own back-link.
- R8: Completing an ID that is absent from the chain holds busy high for one cycle per chain entry, counting the running ID, and changes no link.
- R9: A live completion of ID i by CPU c raises set_vld with set_id=i and set_mask holding only bit c, when all of these hold:
  - i is below NIRQ;
  - i is level-triggered (edge bit 0) and enabled;
  - i's level input is high;
  - target bit i*NCPU+c is 1.
  Otherwise no set pulse is raised.
- R10: Only bits 9:0 of req_data are taken as the completed ID. Higher bits have no effect.
- R11: A request presented while busy is high is dropped and has no effect.
- R12: Running IDs, priorities and back-links of one CPU are unaffected by requests of another CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe, one cycle per request |
| req_op | input | 1 | 0 acknowledge, 1 end-of-interrupt |
| req_cpu | input | CPU_W | Requesting CPU |
| req_data | input | DATA_W | Completion value; ID in bits 9:0 |
| hp_id_flat | input | NCPU*10 | Best pending ID per CPU, 1023 for none |
| prio_flat | input | NIRQ*8 | Priority per ID, lower is more urgent |
| edge_cfg | input | NIRQ | 1 edge-triggered, 0 level-triggered |
| oneofn_cfg | input | NIRQ | 1 for 1-of-N delivery, 0 for N-to-N |
| enable_cfg | input | NIRQ | Source enable |
| level_in | input | NIRQ | Current source input level |
| target_flat | input | NIRQ*NCPU | Target bit for ID i, CPU c at i*NCPU+c |
| run_id_flat | output | NCPU*10 | Running ID per CPU |
| run_pri_flat | output | NCPU*9 | Running priority per CPU |
| busy | output | 1 | Chain walk in progress; requests dropped |
| rsp_vld | output | 1 | Acknowledge answer valid |
| rsp_id | output | 10 | Acknowledged ID, or 1023 |
| clr_vld | output | 1 | Pending clear pulse |
| clr_id | output | 10 | ID to clear |
| clr_mask | output | NCPU | CPUs whose pending bit is cleared |
| set_vld | output | 1 | Re-pend pulse |
| set_id | output | 10 | ID to re-pend |
| set_mask | output | NCPU | CPU whose pending bit is set |

## Verification
A three-deep nest is built on one CPU with IDs of rising urgency while the other CPU takes its own interrupt. This separates a correct back-link from one that is overwritten or shared between CPUs. Acknowledges are also offered at equal priority, with no pending ID and with an out-of-range ID, which tells a strict priority comparison apart from a non-strict one. A deep entry is completed out of order, with high bits set in the completion value. An absent ID is completed as well. Each walk length is compared with the chain position, and the later in-order completions show whether the splice really removed the entry. Re-pend is tried with the level source asserted, with its target bit cleared and with edge trigger, so each gating term is exercised on its own.

// File: rtl/ackt_pkg.sv
package ackt_pkg;
  localparam int ID_W   = 10;
  localparam int PRI_W  = 8;
  localparam int RPRI_W = PRI_W + 1;
  localparam logic [ID_W-1:0]   NO_ID    = 10'd1023;
  localparam logic [RPRI_W-1:0] IDLE_PRI = 9'h100;

  typedef enum logic {OP_ACK = 1'b0, OP_EOI = 1'b1} op_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} walk_st_e;
endpackage

// File: rtl/ackt_linkstore.sv
module ackt_linkstore
  import ackt_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NIRQ = 32,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int DEPTH = NIRQ * NCPU,
  localparam int DEP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   ra_irq,
  input  logic [CPU_W-1:0]  ra_cpu,
  output logic [ID_W-1:0]   ra_data,
  input  logic [ID_W-1:0]   rb_irq,
  input  logic [CPU_W-1:0]  rb_cpu,
  output logic [ID_W-1:0]   rb_data,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_irq,
  input  logic [CPU_W-1:0]  wr_cpu,
  input  logic [ID_W-1:0]   wr_data
);
  logic [ID_W-1:0] link_q [DEPTH];

  function automatic logic in_range(input logic [ID_W-1:0] irq, input logic [CPU_W-1:0] cpu);
    return (int'(irq) < NIRQ) && (int'(cpu) < NCPU);
  endfunction

  function automatic logic [DEP_W-1:0] slot(input logic [ID_W-1:0] irq, input logic [CPU_W-1:0] cpu);
    return DEP_W'(int'(irq) * NCPU + int'(cpu));
  endfunction

  assign ra_data = in_range(ra_irq, ra_cpu) ? link_q[slot(ra_irq, ra_cpu)] : NO_ID;
  assign rb_data = in_range(rb_irq, rb_cpu) ? link_q[slot(rb_irq, rb_cpu)] : NO_ID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) link_q[i] <= NO_ID;
    end else if (wr_en && in_range(wr_irq, wr_cpu)) begin
      link_q[slot(wr_irq, wr_cpu)] <= wr_data;
    end
  end

  AST_NO_SELF_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data != wr_irq) else $error("back-link points at itself"); // R3
endmodule

// File: rtl/ackt_runreg.sv
module ackt_runreg
  import ackt_pkg::*;
#(
  parameter int NCPU = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCPU-1:0]          ld_en,
  input  logic [ID_W-1:0]          ld_id,
  input  logic [RPRI_W-1:0]        ld_pri,
  output logic [NCPU*ID_W-1:0]     run_id_flat,
  output logic [NCPU*RPRI_W-1:0]   run_pri_flat
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [ID_W-1:0]   run_q;
    logic [RPRI_W-1:0] pri_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q <= NO_ID;
        pri_q <= IDLE_PRI;
      end else if (ld_en[c]) begin
        run_q <= ld_id;
        pri_q <= ld_pri;
      end
    end

    assign run_id_flat[c*ID_W +: ID_W]       = run_q;
    assign run_pri_flat[c*RPRI_W +: RPRI_W]  = pri_q;

    AST_IDLE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == NO_ID) |-> (pri_q == IDLE_PRI)) else $error("idle CPU with a rank"); // R6
    AST_BUSY_RANK: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != NO_ID) |-> (pri_q < IDLE_PRI)) else $error("running CPU at idle rank"); // R3
  end
endmodule

// File: rtl/ackt_ctrl.sv
module ackt_ctrl
  import ackt_pkg::*;
#(
  parameter int NCPU   = 2,
  parameter int NIRQ   = 32,
  parameter int DATA_W = 16,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_vld,
  input  logic                     req_op,
  input  logic [CPU_W-1:0]         req_cpu,
  input  logic [DATA_W-1:0]        req_data,
  input  logic [NCPU*ID_W-1:0]     hp_id_flat,
  input  logic [NIRQ*PRI_W-1:0]    prio_flat,
  input  logic [NIRQ-1:0]          edge_cfg,
  input  logic [NIRQ-1:0]          oneofn_cfg,
  input  logic [NIRQ-1:0]          enable_cfg,
  input  logic [NIRQ-1:0]          level_in,
  input  logic [NIRQ*NCPU-1:0]     target_flat,
  input  logic [NCPU*ID_W-1:0]     run_id_flat,
  input  logic [NCPU*RPRI_W-1:0]   run_pri_flat,
  output logic [ID_W-1:0]          la_irq,
  output logic [CPU_W-1:0]         la_cpu,
  input  logic [ID_W-1:0]          la_data,
  output logic [ID_W-1:0]          lb_irq,
  output logic [CPU_W-1:0]         lb_cpu,
  input  logic [ID_W-1:0]          lb_data,
  output logic                     lw_en,
  output logic [ID_W-1:0]          lw_irq,
  output logic [CPU_W-1:0]         lw_cpu,
  output logic [ID_W-1:0]          lw_data,
  output logic [NCPU-1:0]          ld_en,
  output logic [ID_W-1:0]          ld_id,
  output logic [RPRI_W-1:0]        ld_pri,
  output logic                     busy,
  output logic                     rsp_vld,
  output logic [ID_W-1:0]          rsp_id,
  output logic                     clr_vld,
  output logic [ID_W-1:0]          clr_id,
  output logic [NCPU-1:0]          clr_mask,
  output logic                     set_vld,
  output logic [ID_W-1:0]          set_id,
  output logic [NCPU-1:0]          set_mask
);
  localparam logic [NCPU-1:0] ONE_CPU = 1;
  localparam logic [NCPU-1:0] ALL_CPU = '1;
  localparam int CNT_W = $clog2(NIRQ + 1);

  function automatic logic [PRI_W-1:0] prio_of(input logic [ID_W-1:0] id);
    logic [PRI_W-1:0] r;
    r = '0;
    for (int i = 0; i < NIRQ; i++)
      if (id == ID_W'(i)) r = prio_flat[i*PRI_W +: PRI_W];
    return r;
  endfunction

  function automatic logic [RPRI_W-1:0] rank_of(input logic [ID_W-1:0] id);
    return (id == NO_ID) ? IDLE_PRI : {1'b0, prio_of(id)};
  endfunction

  function automatic logic cfg_bit(input logic [NIRQ-1:0] v, input logic [ID_W-1:0] id);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (id == ID_W'(i)) r = v[i];
    return r;
  endfunction

  function automatic logic tgt_bit(input logic [ID_W-1:0] id, input logic [CPU_W-1:0] cpu);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      for (int c = 0; c < NCPU; c++)
        if (id == ID_W'(i) && cpu == CPU_W'(c)) r = target_flat[i*NCPU + c];
    return r;
  endfunction

  function automatic logic [ID_W-1:0] pick_id(input logic [NCPU*ID_W-1:0] flat, input logic [CPU_W-1:0] cpu);
    logic [ID_W-1:0] r;
    r = NO_ID;
    for (int c = 0; c < NCPU; c++)
      if (cpu == CPU_W'(c)) r = flat[c*ID_W +: ID_W];
    return r;
  endfunction

  function automatic logic [RPRI_W-1:0] pick_pri(input logic [CPU_W-1:0] cpu);
    logic [RPRI_W-1:0] r;
    r = IDLE_PRI;
    for (int c = 0; c < NCPU; c++)
      if (cpu == CPU_W'(c)) r = run_pri_flat[c*RPRI_W +: RPRI_W];
    return r;
  endfunction

  walk_st_e          st_q;
  logic [ID_W-1:0]   w_tmp_q, w_id_q;
  logic [CPU_W-1:0]  w_cpu_q;
  logic [CNT_W-1:0]  w_cnt_q;

  // named internal events
  logic              accept, ack_go, eoi_go, ack_ok, eoi_hit, repend_ok;
  logic              walk_match, walk_end;
  logic [ID_W-1:0]   cur_run, ack_cand, eoi_id;
  logic [RPRI_W-1:0] cur_rpri;
  logic [NCPU-1:0]   cpu_oh;

  assign busy     = (st_q == ST_WALK);
  assign accept   = req_vld && !busy && (int'(req_cpu) < NCPU);
  assign cur_run  = pick_id(run_id_flat, req_cpu);
  assign cur_rpri = pick_pri(req_cpu);
  assign cpu_oh   = ONE_CPU << req_cpu;

  assign ack_cand = pick_id(hp_id_flat, req_cpu);
  assign ack_ok   = (int'(ack_cand) < NIRQ) && ({1'b0, prio_of(ack_cand)} < cur_rpri);
  assign ack_go   = accept && (req_op == OP_ACK);

  assign eoi_id    = req_data[ID_W-1:0];
  assign eoi_go    = accept && (req_op == OP_EOI) && (cur_run != NO_ID);
  assign eoi_hit   = (eoi_id == cur_run);
  assign repend_ok = (int'(eoi_id) < NIRQ) && !cfg_bit(edge_cfg, eoi_id)
                     && cfg_bit(enable_cfg, eoi_id) && cfg_bit(level_in, eoi_id)
                     && tgt_bit(eoi_id, req_cpu);

  assign walk_match = busy && (la_data == w_id_q);
  assign walk_end   = busy && ((la_data == NO_ID) || walk_match);

  assign la_irq = busy ? w_tmp_q : cur_run;
  assign la_cpu = busy ? w_cpu_q : req_cpu;
  assign lb_irq = w_id_q;
  assign lb_cpu = w_cpu_q;

  assign lw_en   = (ack_go && ack_ok) || walk_match;
  assign lw_irq  = busy ? w_tmp_q : ack_cand;
  assign lw_cpu  = busy ? w_cpu_q : req_cpu;
  assign lw_data = busy ? lb_data : cur_run;

  always_comb begin
    ld_en = '0;
    if ((ack_go && ack_ok) || (eoi_go && eoi_hit)) ld_en = cpu_oh;
    ld_id  = ack_go ? ack_cand : la_data;
    ld_pri = rank_of(ld_id);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      w_tmp_q  <= NO_ID;
      w_id_q   <= NO_ID;
      w_cpu_q  <= '0;
      w_cnt_q  <= '0;
      rsp_vld  <= 1'b0;
      rsp_id   <= NO_ID;
      clr_vld  <= 1'b0;
      clr_id   <= NO_ID;
      clr_mask <= '0;
      set_vld  <= 1'b0;
      set_id   <= NO_ID;
      set_mask <= '0;
    end else begin
      rsp_vld <= ack_go;
      rsp_id  <= (ack_go && ack_ok) ? ack_cand : NO_ID;
      clr_vld <= ack_go && ack_ok;
      if (ack_go && ack_ok) begin
        clr_id   <= ack_cand;
        clr_mask <= cfg_bit(oneofn_cfg, ack_cand) ? ALL_CPU : cpu_oh;
      end
      set_vld <= eoi_go && repend_ok;
      if (eoi_go && repend_ok) begin
        set_id   <= eoi_id;
        set_mask <= cpu_oh;
      end
      case (st_q)
        ST_IDLE: if (eoi_go && !eoi_hit) begin
          st_q    <= ST_WALK;
          w_tmp_q <= cur_run;
          w_id_q  <= eoi_id;
          w_cpu_q <= req_cpu;
          w_cnt_q <= '0;
        end
        ST_WALK: if (walk_end) begin
          st_q <= ST_IDLE;
        end else begin
          w_tmp_q <= la_data;
          w_cnt_q <= w_cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && req_vld)
      AST_REQ_DATA_KNOWN: assert (!$isunknown(req_data)) else $error("unknown completion value"); // R10
  end

  AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> int'(w_cnt_q) < NIRQ) else $error("chain walk too long"); // R8
  AST_CLR_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld |-> (clr_mask != '0) && rsp_vld && (rsp_id == clr_id)) else $error("clear pulse malformed"); // R4
  AST_SET_ONE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld |-> $countones(set_mask) == 1) else $error("re-pend mask not one CPU"); // R9
  AST_RSP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_id != NO_ID) |-> int'(rsp_id) < NIRQ) else $error("answer out of range"); // R3
  AST_ONE_PULSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_vld, set_vld})) else $error("answer and re-pend together"); // R11
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
  import ackt_pkg::*;
#(
  parameter int NCPU   = 2,
  parameter int NIRQ   = 32,
  parameter int DATA_W = 16,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_vld,
  input  logic                     req_op,
  input  logic [CPU_W-1:0]         req_cpu,
  input  logic [DATA_W-1:0]        req_data,
  input  logic [NCPU*ID_W-1:0]     hp_id_flat,
  input  logic [NIRQ*PRI_W-1:0]    prio_flat,
  input  logic [NIRQ-1:0]          edge_cfg,
  input  logic [NIRQ-1:0]          oneofn_cfg,
  input  logic [NIRQ-1:0]          enable_cfg,
  input  logic [NIRQ-1:0]          level_in,
  input  logic [NIRQ*NCPU-1:0]     target_flat,
  output logic [NCPU*ID_W-1:0]     run_id_flat,
  output logic [NCPU*RPRI_W-1:0]   run_pri_flat,
  output logic                     busy,
  output logic                     rsp_vld,
  output logic [ID_W-1:0]          rsp_id,
  output logic                     clr_vld,
  output logic [ID_W-1:0]          clr_id,
  output logic [NCPU-1:0]          clr_mask,
  output logic                     set_vld,
  output logic [ID_W-1:0]          set_id,
  output logic [NCPU-1:0]          set_mask
);
  logic [ID_W-1:0]   la_irq, la_data, lb_irq, lb_data, lw_irq, lw_data, ld_id;
  logic [CPU_W-1:0]  la_cpu, lb_cpu, lw_cpu;
  logic              lw_en;
  logic [NCPU-1:0]   ld_en;
  logic [RPRI_W-1:0] ld_pri;

  ackt_ctrl #(.NCPU(NCPU), .NIRQ(NIRQ), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_op(req_op), .req_cpu(req_cpu), .req_data(req_data),
    .hp_id_flat(hp_id_flat), .prio_flat(prio_flat), .edge_cfg(edge_cfg),
    .oneofn_cfg(oneofn_cfg), .enable_cfg(enable_cfg), .level_in(level_in),
    .target_flat(target_flat), .run_id_flat(run_id_flat), .run_pri_flat(run_pri_flat),
    .la_irq(la_irq), .la_cpu(la_cpu), .la_data(la_data),
    .lb_irq(lb_irq), .lb_cpu(lb_cpu), .lb_data(lb_data),
    .lw_en(lw_en), .lw_irq(lw_irq), .lw_cpu(lw_cpu), .lw_data(lw_data),
    .ld_en(ld_en), .ld_id(ld_id), .ld_pri(ld_pri),
    .busy(busy), .rsp_vld(rsp_vld), .rsp_id(rsp_id),
    .clr_vld(clr_vld), .clr_id(clr_id), .clr_mask(clr_mask),
    .set_vld(set_vld), .set_id(set_id), .set_mask(set_mask)
  );

  ackt_linkstore #(.NCPU(NCPU), .NIRQ(NIRQ)) u_links (
    .clk(clk), .rst_n(rst_n),
    .ra_irq(la_irq), .ra_cpu(la_cpu), .ra_data(la_data),
    .rb_irq(lb_irq), .rb_cpu(lb_cpu), .rb_data(lb_data),
    .wr_en(lw_en), .wr_irq(lw_irq), .wr_cpu(lw_cpu), .wr_data(lw_data)
  );

  ackt_runreg #(.NCPU(NCPU)) u_run (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_id(ld_id), .ld_pri(ld_pri),
    .run_id_flat(run_id_flat), .run_pri_flat(run_pri_flat)
  );

  AST_RUN_HELD_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(run_id_flat)) else $error("running ID moved during walk"); // R7
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !rsp_vld && !set_vld) else $error("activity right after reset"); // R1
endmodule

// File: tb/sim_irq_ack_tracker.sv
`timescale 1ns/1ps
module sim_irq_ack_tracker;
  localparam int NCPU = 2;
  localparam int NIRQ = 32;
  localparam int NONE = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_vld = 1'b0, req_op = 1'b0;
  logic [0:0]        req_cpu = '0;
  logic [15:0]       req_data = '0;
  logic [NCPU*10-1:0] hp_id_flat;
  logic [NIRQ*8-1:0]  prio_flat;
  logic [NIRQ-1:0]    edge_cfg, oneofn_cfg, enable_cfg, level_in;
  logic [NIRQ*NCPU-1:0] target_flat;
  logic [NCPU*10-1:0] run_id_flat;
  logic [NCPU*9-1:0]  run_pri_flat;
  logic busy, rsp_vld, clr_vld, set_vld;
  logic [9:0] rsp_id, clr_id, set_id;
  logic [NCPU-1:0] clr_mask, set_mask;

  irq_ack_tracker #(.NCPU(NCPU), .NIRQ(NIRQ), .DATA_W(16)) u0 (.*);

  // stimulus tables and reference model
  int hp_t[NCPU];
  int prio_t[NIRQ];
  bit edge_t[NIRQ], onen_t[NIRQ], en_t[NIRQ], lvl_t[NIRQ];
  bit tgt_t[NIRQ][NCPU];
  int m_run[NCPU];
  int m_link[NCPU][NIRQ];
  int busy_left;
  bit e_rsp, e_clr, e_set;
  int e_rsp_id, e_clr_id, e_clr_mask, e_set_id, e_set_mask;
  int nchk = 0, nfail = 0;
  string tag;

  always_comb begin
    for (int c = 0; c < NCPU; c++) hp_id_flat[c*10 +: 10] = 10'(hp_t[c]);
    for (int i = 0; i < NIRQ; i++) begin
      prio_flat[i*8 +: 8] = 8'(prio_t[i]);
      edge_cfg[i] = edge_t[i];
      oneofn_cfg[i] = onen_t[i];
      enable_cfg[i] = en_t[i];
      level_in[i] = lvl_t[i];
      for (int c = 0; c < NCPU; c++) target_flat[i*NCPU + c] = tgt_t[i][c];
    end
  end

  function automatic int rank(int id);
    return (id == NONE) ? 256 : prio_t[id];
  endfunction

  task automatic chk(string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    for (int c = 0; c < NCPU; c++) begin
      chk($sformatf("run_id cpu%0d", c), int'(run_id_flat[c*10 +: 10]), m_run[c]);
      chk($sformatf("run_pri cpu%0d", c), int'(run_pri_flat[c*9 +: 9]), rank(m_run[c]));
    end
    chk("busy", int'(busy), int'(busy_left > 0));
    chk("rsp_vld", int'(rsp_vld), int'(e_rsp));
    if (e_rsp) chk("rsp_id", int'(rsp_id), e_rsp_id);
    chk("clr_vld", int'(clr_vld), int'(e_clr));
    if (e_clr) begin
      chk("clr_id", int'(clr_id), e_clr_id);
      chk("clr_mask", int'(clr_mask), e_clr_mask);
    end
    chk("set_vld", int'(set_vld), int'(e_set));
    if (e_set) begin
      chk("set_id", int'(set_id), e_set_id);
      chk("set_mask", int'(set_mask), e_set_mask);
    end
    e_rsp = 0; e_clr = 0; e_set = 0;
    if (busy_left > 0) busy_left--;
  endtask

  task automatic issue(bit op, int cpu, int data);
    req_vld = 1'b1; req_op = op; req_cpu = 1'(cpu); req_data = 16'(data);
    if (busy_left == 0) begin
      if (!op) begin
        int cand = hp_t[cpu];
        bit ok = (cand < NIRQ) && (prio_t[cand] < rank(m_run[cpu]));
        e_rsp = 1; e_rsp_id = ok ? cand : NONE;
        if (ok) begin
          m_link[cpu][cand] = m_run[cpu];
          m_run[cpu] = cand;
          e_clr = 1; e_clr_id = cand;
          e_clr_mask = onen_t[cand] ? 3 : (1 << cpu);
        end
      end else if (m_run[cpu] != NONE) begin
        int id = data % 1024;
        if (id < NIRQ && !edge_t[id] && en_t[id] && lvl_t[id] && tgt_t[id][cpu]) begin
          e_set = 1; e_set_id = id; e_set_mask = 1 << cpu;
        end
        if (id == m_run[cpu]) m_run[cpu] = m_link[cpu][id];
        else begin
          int cur = m_run[cpu];
          int steps = 0;
          forever begin
            int nxt = m_link[cpu][cur];
            steps++;
            if (nxt == NONE) break;
            if (nxt == id) begin
              m_link[cpu][cur] = m_link[cpu][id];
              break;
            end
            cur = nxt;
          end
          busy_left = steps;
        end
      end
    end
    tick();
    req_vld = 1'b0;
  endtask

  task automatic drain();
    while (busy_left > 0) tick();
    tick();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCPU; c++) begin
      hp_t[c] = NONE; m_run[c] = NONE;
      for (int i = 0; i < NIRQ; i++) m_link[c][i] = NONE;
    end
    for (int i = 0; i < NIRQ; i++) begin
      prio_t[i] = 200 - 5 * i;
      edge_t[i] = 0; onen_t[i] = 0; en_t[i] = 1; lvl_t[i] = 0;
      for (int c = 0; c < NCPU; c++) tgt_t[i][c] = 1;
    end
    onen_t[3] = 1;
    busy_left = 0; e_rsp = 0; e_clr = 0; e_set = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    tag = "R1 reset state";
    tick();

    tag = "R2 nothing pending";
    issue(0, 0, 0);
    tag = "R2 offered ID out of range";
    hp_t[0] = 40; issue(0, 0, 0);

    tag = "R5 completion while idle";
    lvl_t[5] = 1; issue(1, 0, 5);

    tag = "R3 R4 acknowledge 1-of-N ID";
    hp_t[0] = 3; issue(0, 0, 0);
    tag = "R2 equal priority refused";
    issue(0, 0, 0);
    tag = "R4 acknowledge N-to-N ID";
    hp_t[0] = 7; issue(0, 0, 0);
    tag = "R3 nest third level";
    hp_t[0] = 12; issue(0, 0, 0);
    tag = "R12 other CPU independent";
    hp_t[1] = 20; issue(0, 1, 0);

    tag = "R7 R10 out-of-order completion";
    issue(1, 0, 16'hFC03);
    tag = "R11 request while busy dropped";
    hp_t[1] = 25; issue(0, 1, 0);
    drain();

    tag = "R8 absent ID walk";
    issue(1, 0, 9);
    drain();

    tag = "R6 R9 complete running, level re-pend";
    lvl_t[12] = 1; issue(1, 0, 12);
    tag = "R7 R9 splice seen, target off";
    lvl_t[7] = 1; tgt_t[7][0] = 0; issue(1, 0, 7);
    tag = "R6 R9 edge source not re-pended";
    edge_t[20] = 1; lvl_t[20] = 1; issue(1, 1, 20);
    tag = "R11 accepted after walk";
    issue(0, 1, 0);
    tag = "R5 completion on idle CPU0";
    issue(1, 0, 25);
    tick();

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule